// File: doc/BRIEF.md
# Resumable Byte-Serial CRC-32 Engine

This block computes the 32-bit cyclic redundancy check used as a link-layer frame check sequence. It takes one byte per clock. The register is kept in reflected form: the highest-order term of the remainder sits in bit 0. Each accepted byte updates the remainder through a 256-entry feedback term. The term is built in logic from the polynomial, either as a constant table or as eight shift/XOR stages, and a parameter selects which.

A message need not be processed in one pass. A start pulse loads a 32-bit seed, and the seed is inverted on the way in. The output is the register inverted on the way out. Because of this pairing, any value the block has returned can be supplied later as a seed to continue the same message. A seed of zero begins a fresh message.

An optional transmit shifter captures the current result on request. It then offers the result one bit per cycle under a ready/valid handshake, starting from bit 0. This sends the low byte first, with each byte least significant bit first, so the terms go out from highest order to lowest with no reordering.

Top module: `crc_resume_engine`

## Requirements
- R1: After synchronous reset the internal remainder is all ones, so `crc_o` reads 0x00000000 and `ser_valid_o` is low.
- R2: A cycle with `start_i` high and `byte_valid_i` low loads the remainder with `seed_i` XOR 0xFFFFFFFF, so on the next cycle `crc_o` equals the seed.
- R3: A cycle with `byte_valid_i` high replaces the remainder r with T[(r XOR byte) AND 0xFF] XOR (r >> 8), zero-filled from the top, using the reflected polynomial constant 0xEDB88320. `crc_o` shows the new value (inverted) on the next cycle.
- R4: A cycle with both `start_i` and `byte_valid_i` low leaves `crc_o` unchanged, whatever `byte_i` and `seed_i` carry.
- R5: When `start_i` and `byte_valid_i` are high in the same cycle, the seed is applied first and the byte is then folded into the seeded remainder.
- R6: The nine ASCII bytes 0x31..0x39 ("123456789") given back-to-back after a start with seed 0 yield 0x CBF43926 on `crc_o`.
- R7: Splitting any message at any point and restarting the second piece with the first piece's `crc_o` as seed gives the same final value as one pass.
- R8: Each feedback term T[i] equals eight reflected shift/conditional-XOR steps applied to i; for example T[1] = 0x77073096 and T[128] = 0xEDB88320.
- R9: A `ser_load_i` pulse while the shifter is idle captures `crc_o`, and the shifter then presents bits 0 through 31 of the captured value in that order, one per accepted transfer.
- R10: While `ser_valid_o` is high and `ser_ready_i` is low, `ser_bit_o` and `ser_valid_o` hold.
- R11: `ser_last_o` is high exactly on the 32nd bit. `ser_valid_o` falls after that bit is accepted.
- R12: A `ser_load_i` pulse while the shifter is busy is ignored, and the word being sent is not replaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin or resume a message with `seed_i` |
| seed_i | input | 32 | Seed: 0 for a new message, or an earlier result to resume |
| byte_valid_i | input | 1 | `byte_i` carries a message byte this cycle |
| byte_i | input | 8 | Message byte |
| crc_o | output | 32 | Check value of all bytes accepted so far |
| ser_load_i | input | 1 | Capture `crc_o` into the transmit shifter |
| ser_ready_i | input | 1 | Receiver accepts the offered bit |
| ser_valid_o | output | 1 | A check-value bit is being offered |
| ser_bit_o | output | 1 | Offered bit |
| ser_last_o | output | 1 | Offered bit is the final one of the word |

## Verification
The bench builds the engine with its default parameters: the table form of the feedback terms and the transmit shifter enabled. With only 256 possible indices, it drives every index through a seed-plus-byte cycle and every byte value from a zero seed. Each result is compared with a bit-serial model in the bench. It also exercises every split point of the nine-byte check string, and runs the shifter both with free-flowing ready and with a stall pattern that includes a load attempt during transmission.

// File: rtl/crc_resume_pkg.sv
package crc_resume_pkg;

    localparam int CRC_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int TAB_DEPTH = 1 << BYTE_W;
    localparam int SER_CNT_W = $clog2(CRC_W + 1);

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam crc_t REFL_POLY = 32'hEDB88320;
    localparam crc_t ALL_ONES  = '1;

    // Encoded as {byte_valid, start}
    typedef enum logic [1:0] {
        ACT_HOLD      = 2'b00,
        ACT_SEED      = 2'b01,
        ACT_BYTE      = 2'b10,
        ACT_SEED_BYTE = 2'b11
    } acc_act_e;

    typedef struct packed {
        crc_t                 shreg;
        logic [SER_CNT_W-1:0] left;
    } ser_state_t;

    // Eight reflected shift/conditional-XOR steps starting from idx
    function automatic crc_t fb_term(input byte_t idx, input crc_t poly);
        crc_t c;
        c = crc_t'(idx);
        for (int k = 0; k < BYTE_W; k++) begin
            c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_resume_pkg::*;
#(
    parameter crc_t POLY      = REFL_POLY,
    parameter bit   USE_TABLE = 1'b1
) (
    input  crc_t  cur_i,
    input  byte_t data_i,
    output crc_t  nxt_o
);

    byte_t idx;
    crc_t  term;

    assign idx = cur_i[BYTE_W-1:0] ^ data_i;

    generate
        if (USE_TABLE) begin : g_table
            crc_t tab [TAB_DEPTH];
            for (genvar i = 0; i < TAB_DEPTH; i++) begin : g_entry
                assign tab[i] = fb_term(byte_t'(i), POLY);
            end
            always_comb term = tab[idx];
        end else begin : g_calc
            always_comb term = fb_term(idx, POLY);
        end
    endgenerate

    // Logical shift: zeros enter from the top
    assign nxt_o = term ^ (cur_i >> BYTE_W);

endmodule

// File: rtl/crc_accum.sv
module crc_accum
    import crc_resume_pkg::*;
#(
    parameter crc_t POLY      = REFL_POLY,
    parameter crc_t SEED_XOR  = ALL_ONES,
    parameter crc_t RST_VAL   = ALL_ONES,
    parameter bit   USE_TABLE = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  crc_t  seed_i,
    input  logic  byte_valid_i,
    input  byte_t byte_i,
    output crc_t  rem_o
);

    acc_act_e act;
    crc_t     rem_q;
    crc_t     base;
    crc_t     stepped;

    assign act = acc_act_e'({byte_valid_i, start_i});

    // The seed, when present, takes precedence as the starting remainder
    always_comb begin
        if (act == ACT_SEED || act == ACT_SEED_BYTE) base = seed_i ^ SEED_XOR;
        else                                         base = rem_q;
    end

    crc_byte_step #(
        .POLY      (POLY),
        .USE_TABLE (USE_TABLE)
    ) u_step (
        .cur_i  (base),
        .data_i (byte_i),
        .nxt_o  (stepped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= RST_VAL;
        end else begin
            unique case (act)
                ACT_HOLD:                rem_q <= rem_q;
                ACT_SEED:                rem_q <= base;
                ACT_BYTE, ACT_SEED_BYTE: rem_q <= stepped;
                default:                 rem_q <= rem_q;
            endcase
        end
    end

    assign rem_o = rem_q;

endmodule

// File: rtl/crc_tx_shifter.sv
module crc_tx_shifter
    import crc_resume_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  crc_t word_i,
    input  logic ready_i,
    output logic valid_o,
    output logic bit_o,
    output logic last_o
);

    ser_state_t st_q;
    logic       busy;

    assign busy = (st_q.left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (load_i && !busy) begin
            st_q.shreg <= word_i;
            st_q.left  <= SER_CNT_W'(CRC_W);
        end else if (busy && ready_i) begin
            st_q.shreg <= st_q.shreg >> 1;
            st_q.left  <= st_q.left - 1'b1;
        end
    end

    assign valid_o = busy;
    assign bit_o   = st_q.shreg[0];
    assign last_o  = (st_q.left == SER_CNT_W'(1));

endmodule

// File: rtl/crc_resume_engine.sv
module crc_resume_engine
    import crc_resume_pkg::*;
#(
    parameter crc_t POLY      = REFL_POLY,
    parameter crc_t SEED_XOR  = ALL_ONES,
    parameter crc_t OUT_XOR   = ALL_ONES,
    parameter bit   USE_TABLE = 1'b1,
    parameter bit   SER_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CRC_W-1:0]  seed_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o,
    input  logic              ser_load_i,
    input  logic              ser_ready_i,
    output logic              ser_valid_o,
    output logic              ser_bit_o,
    output logic              ser_last_o
);

    crc_t rem;

    crc_accum #(
        .POLY      (POLY),
        .SEED_XOR  (SEED_XOR),
        .RST_VAL   (ALL_ONES),
        .USE_TABLE (USE_TABLE)
    ) u_accum (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .seed_i       (seed_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .rem_o        (rem)
    );

    assign crc_o = rem ^ OUT_XOR;

    generate
        if (SER_EN) begin : g_ser
            crc_tx_shifter u_ser (
                .clk     (clk),
                .rst     (rst),
                .load_i  (ser_load_i),
                .word_i  (crc_o),
                .ready_i (ser_ready_i),
                .valid_o (ser_valid_o),
                .bit_o   (ser_bit_o),
                .last_o  (ser_last_o)
            );
        end else begin : g_no_ser
            assign ser_valid_o = 1'b0;
            assign ser_bit_o   = 1'b0;
            assign ser_last_o  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/crc_resume_engine_chk.sv
module crc_resume_engine_chk
    import crc_resume_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CRC_W-1:0] seed_i,
    input logic             byte_valid_i,
    input logic [CRC_W-1:0] crc_o,
    input logic             ser_load_i,
    input logic             ser_ready_i,
    input logic             ser_valid_o,
    input logic             ser_bit_o,
    input logic             ser_last_o
);

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (crc_o == '0 && !ser_valid_o));

    assert_seed_load_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !byte_valid_i) |=> (crc_o == $past(seed_i)));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !byte_valid_i) |=> $stable(crc_o));

    assert_ser_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (ser_load_i && !ser_valid_o) |=> (ser_valid_o && ser_bit_o == $past(crc_o[0])));

    assert_ser_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (ser_valid_o && !ser_ready_i) |=> (ser_valid_o && $stable(ser_bit_o)));

    assert_last_valid_R11: assert property (@(posedge clk) disable iff (rst)
        ser_last_o |-> ser_valid_o);

    assert_last_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (ser_last_o && ser_ready_i && !ser_load_i) |=> !ser_valid_o);

    assert_busy_load_R12: assert property (@(posedge clk) disable iff (rst)
        (ser_valid_o && !ser_ready_i && ser_load_i) |=> $stable(ser_bit_o));

endmodule

bind crc_resume_engine crc_resume_engine_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .seed_i       (seed_i),
    .byte_valid_i (byte_valid_i),
    .crc_o        (crc_o),
    .ser_load_i   (ser_load_i),
    .ser_ready_i  (ser_ready_i),
    .ser_valid_o  (ser_valid_o),
    .ser_bit_o    (ser_bit_o),
    .ser_last_o   (ser_last_o)
);

// File: tb/crc_resume_engine_test.sv
`timescale 1ns/1ps
module crc_resume_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [31:0] crc_o;
    logic        ser_load_i = 1'b0;
    logic        ser_ready_i = 1'b0;
    logic        ser_valid_o;
    logic        ser_bit_o;
    logic        ser_last_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    crc_resume_engine uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .seed_i       (seed_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .crc_o        (crc_o),
        .ser_load_i   (ser_load_i),
        .ser_ready_i  (ser_ready_i),
        .ser_valid_o  (ser_valid_o),
        .ser_bit_o    (ser_bit_o),
        .ser_last_o   (ser_last_o)
    );

    // Bit-serial reference: raw reflected remainder, one bit at a time
    function automatic logic [31:0] ref_feed(input logic [31:0] r, input logic [7:0] b);
        logic [31:0] c;
        logic        fb;
        c = r;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ b[i];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    function automatic logic [7:0] msg_byte(input int k);
        return 8'h31 + 8'(k);
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus, starting and ending at a falling edge
    task automatic cyc(input logic st, input logic [31:0] sd, input logic v, input logic [7:0] b);
        start_i = st; seed_i = sd; byte_valid_i = v; byte_i = b;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Transmit-shifter run with optional stalls and a load attempt while busy
    task automatic ser_run(input logic [31:0] exp, input int stall_mod, input int poke_at, input string tag);
        logic [31:0] got;
        int n;
        int last_err;
        got = '0; n = 0; last_err = 0;
        ser_load_i = 1'b1;
        @(negedge clk);
        ser_load_i = 1'b0;
        check32({tag, " R9 valid after load"}, {31'd0, ser_valid_o}, 32'd1);
        for (int k = 0; k < 400 && n < 32; k++) begin
            logic rdy;
            rdy = (stall_mod == 0) || (k % stall_mod != 0);
            ser_ready_i = rdy;
            start_i     = (k == poke_at);
            seed_i      = 32'h5A5A0F0F;
            ser_load_i  = (k == poke_at + 1);
            if (ser_valid_o && rdy) begin
                got[n] = ser_bit_o;
                if (ser_last_o != (n == 31)) last_err++;
                n++;
            end
            @(negedge clk);
        end
        ser_ready_i = 1'b0; ser_load_i = 1'b0; start_i = 1'b0;
        check32({tag, " R9 bit order"}, got, exp);
        check32({tag, " R11 last flag errors"}, 32'(last_err), 32'd0);
        check32({tag, " R11 valid low after word"}, {31'd0, ser_valid_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin : main
        logic [31:0] r;
        logic [31:0] mid;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check32("R1 crc after reset", crc_o, 32'h0);
        check32("R1 ser_valid after reset", {31'd0, ser_valid_o}, 32'd0);

        // R8 + R5: every feedback index via seed and byte in one cycle
        for (int i = 0; i < 256; i++) begin
            cyc(1'b1, ~{24'd0, 8'(i)}, 1'b1, 8'h00);
            check32($sformatf("R8 R5 index %0d", i), crc_o, ~ref_feed({24'd0, 8'(i)}, 8'h00));
        end
        cyc(1'b1, 32'hFFFFFFFE, 1'b1, 8'h00);
        check32("R8 term at index 1", ~crc_o, 32'h77073096);
        cyc(1'b1, 32'hFFFFFF7F, 1'b1, 8'h00);
        check32("R8 term at index 128", ~crc_o, 32'hEDB88320);

        // R2: seeds load as given
        cyc(1'b1, 32'hDEADBEEF, 1'b0, 8'h00);
        check32("R2 seed DEADBEEF", crc_o, 32'hDEADBEEF);
        cyc(1'b1, 32'h00000000, 1'b0, 8'h00);
        check32("R2 seed zero", crc_o, 32'h0);

        // R3: every byte value from a zero seed
        for (int b = 0; b < 256; b++) begin
            cyc(1'b1, 32'h0, 1'b0, 8'h00);
            cyc(1'b0, 32'h0, 1'b1, 8'(b));
            check32($sformatf("R3 byte %02h", b), crc_o, ~ref_feed(32'hFFFFFFFF, 8'(b)));
        end

        // R6: check string in one pass
        cyc(1'b1, 32'h0, 1'b0, 8'h00);
        r = 32'hFFFFFFFF;
        for (int k = 0; k < 9; k++) begin
            cyc(1'b0, 32'h0, 1'b1, msg_byte(k));
            r = ref_feed(r, msg_byte(k));
        end
        check32("R6 check string", crc_o, 32'hCBF43926);
        check32("R6 against model", crc_o, ~r);

        // R4: idle cycles with noise on the data and seed lines
        for (int k = 0; k < 6; k++) begin
            byte_i = 8'(k * 37); seed_i = 32'(k * 32'h01010101);
            @(negedge clk);
            check32("R4 idle hold", crc_o, 32'hCBF43926);
        end

        // R7: every split point; resume with seed and first byte together
        for (int s = 1; s < 9; s++) begin
            cyc(1'b1, 32'h0, 1'b0, 8'h00);
            for (int k = 0; k < s; k++) cyc(1'b0, 32'h0, 1'b1, msg_byte(k));
            mid = crc_o;
            cyc(1'b1, mid, 1'b1, msg_byte(s));
            for (int k = s + 1; k < 9; k++) cyc(1'b0, 32'h0, 1'b1, msg_byte(k));
            check32($sformatf("R7 split at %0d", s), crc_o, 32'hCBF43926);
        end
        // R7: split with a separate seed cycle and an idle gap
        cyc(1'b1, 32'h0, 1'b0, 8'h00);
        for (int k = 0; k < 4; k++) cyc(1'b0, 32'h0, 1'b1, msg_byte(k));
        mid = crc_o;
        cyc(1'b0, 32'h0, 1'b0, 8'h00);
        cyc(1'b1, mid, 1'b0, 8'h00);
        for (int k = 4; k < 9; k++) cyc(1'b0, 32'h0, 1'b1, msg_byte(k));
        check32("R7 split with gap", crc_o, 32'hCBF43926);

        // R9 R11: free-flowing transmit
        ser_run(32'hCBF43926, 0, 1000, "free");
        // R10 R12: stalls, crc_o changed and a load attempted mid-word
        cyc(1'b1, 32'h12345678, 1'b0, 8'h00);
        ser_run(32'h12345678, 3, 5, "R10 R12 stalled");
        check32("R2 seed applied during transmit", crc_o, 32'h5A5A0F0F);

        summary();
    end

endmodule